// File: doc/BRIEF.md
# Two-Lane Serial Sample Word Aligner

This block rebuilds 14-bit converter samples that arrive split across two serial lanes. Each lane carries 7 bits of every sample. Those bits reach the block already captured on both clock edges and already centred in the bit eye, so each lane presents two bits per fast-clock cycle. A small gearbox on each lane packs the bit pairs into 7-bit lane words. A per-lane hunter then finds the word boundary. It compares each word against the lane's share of a known framing sample and shifts the gearbox by one bit whenever the comparison fails.

The lanes do not rely on any frame clock, because the phase of that clock relative to the data is not repeatable across power-ups. Once both lanes hold lock, their words are paired through short queues. Either lane can then be delayed by one whole sample, under a two-bit select, to undo a lane-to-lane skew of one sample. Control logic typically runs the search while the converter sends the framing sample. It then switches the converter to a ramp and sets the delay select so that the two halves of each sample agree. A restart input re-arms the search after a failure.

Top module: `dual_lane_word_aligner`

## Requirements
- R1: After reset, `sample_valid` is 0, `lane_locked` is 00 and `lane_error` is 00.
- R2: Each lane word is 7 bits, with the earliest received bit as its MSB. Within a two-bit input pair, bit 1 is the earlier bit. Lane 0 supplies sample bits 13..7 and lane 1 supplies bits 6..0. A lane never emits words on two consecutive cycles.
- R3: A lane counts a word as matching only if it equals its half of the framing sample 0x3C78. That half is 1111000 on both lanes.
- R4: While searching, a word that does not match causes a single one-bit slip of that lane's gearbox. The next 4 words from that lane are then ignored before testing resumes.
- R5: A lane sets its `lane_locked` bit after 8 consecutive matching words. The bit stays set until restart.
- R6: A lane sets its `lane_error` bit when a word fails to match after 7 slips have already been spent. The bit stays set until restart.
- R7: A one-cycle `restart` pulse clears both lock and error bits on the next cycle and starts a fresh search with zero slips.
- R8: `sample` is {lane-0 word, lane-1 word}. When `lane_delay` bit i is 1, lane i contributes the word that came one sample earlier.
- R9: `sample_valid` is 0 unless both lanes are locked. After both lanes become locked, the first word pair only primes the delay stage and produces no output.
- R10: A change of `lane_delay` suppresses the output for the word pair formed in that cycle. The new selection applies from the next pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast bit-pair clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lane0_bits | input | 2 | Lane 0 bit pair, bit 1 earlier |
| lane1_bits | input | 2 | Lane 1 bit pair, bit 1 earlier |
| restart | input | 1 | Re-arms both boundary searches |
| lane_delay | input | 2 | Bit i delays lane i by one sample |
| sample | output | 14 | Rebuilt sample |
| sample_valid | output | 1 | One-cycle strobe per sample |
| lane_locked | output | 2 | Per-lane boundary lock |
| lane_error | output | 2 | Per-lane search failure |

## Verification
The assertions assume that bits arrive on every cycle. They also assume that `restart` is a pulse and not a level held through a search. The merge-queue checks further assume that both lanes run at the same word rate once locked, with less than one sample of skew between them. The stimulus keeps within these limits. It feeds both lanes from one sample stream, offsets the lanes by whole bits of zero prefix (3 bits on lane 0, 8 bits on lane 1), pulses `restart` for a single cycle, and changes `lane_delay` only while ramp data flows.

// File: rtl/lane_align_pkg.sv
package lane_align_pkg;
   typedef enum logic [1:0] {
      ST_HUNT = 2'd0,
      ST_SKIP = 2'd1,
      ST_LOCK = 2'd2,
      ST_FAIL = 2'd3
   } hunt_st_e;
endpackage

// File: rtl/lane_gearbox.sv
module lane_gearbox #(
   parameter int WORD_W  = 7,
   parameter int BITS_PC = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [BITS_PC-1:0] din_i,
   input  logic               slip_i,
   output logic [WORD_W-1:0]  word_o,
   output logic               wvld_o
);
   localparam int VW = WORD_W - 1 + BITS_PC;
   localparam int CW = $clog2(VW + 1);

   logic [WORD_W-2:0] hold_q;
   logic [CW-1:0]     cnt_q, cnt_d, tot, tot_s;
   logic [VW-1:0]     cat;
   logic [WORD_W-1:0] word_d;
   logic              emit;

   // oldest valid bit sits at cat[tot-1]
   always_comb begin
      cat    = {hold_q, din_i};
      tot    = cnt_q + CW'(BITS_PC);
      tot_s  = tot - CW'(slip_i);
      emit   = (tot_s >= CW'(WORD_W));
      word_d = WORD_W'(cat >> (tot_s - CW'(WORD_W)));
      cnt_d  = emit ? (tot_s - CW'(WORD_W)) : tot_s;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         hold_q <= '0;
         word_o <= '0;
         wvld_o <= 1'b0;
      end else begin
         cnt_q  <= cnt_d;
         hold_q <= cat[WORD_W-2:0];
         wvld_o <= emit;
         if (emit) word_o <= word_d;
      end
   end

   // R2: two bits per cycle can never fill a word on back-to-back cycles
   p_word_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
      wvld_o |=> !wvld_o);
endmodule

// File: rtl/lane_hunter.sv
module lane_hunter
   import lane_align_pkg::*;
#(
   parameter int                WORD_W     = 7,
   parameter logic [WORD_W-1:0] FRAME_WORD = 7'b1111000,
   parameter int                LOCK_RUN   = 8,
   parameter int                SKIP_WORDS = 4,
   parameter int                SLIP_LIMIT = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              restart_i,
   input  logic [WORD_W-1:0] word_i,
   input  logic              wvld_i,
   output logic              slip_o,
   output logic              locked_o,
   output logic              err_o
);
   localparam int MCW = $clog2(LOCK_RUN + 1);
   localparam int SCW = $clog2(SLIP_LIMIT + 1);
   localparam int WCW = $clog2(SKIP_WORDS + 1);

   hunt_st_e       st_q;
   logic [MCW-1:0] run_q;
   logic [SCW-1:0] slips_q;
   logic [WCW-1:0] skip_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= ST_HUNT;
         run_q   <= '0;
         slips_q <= '0;
         skip_q  <= '0;
         slip_o  <= 1'b0;
      end else begin
         slip_o <= 1'b0;
         if (restart_i) begin
            st_q    <= ST_HUNT;
            run_q   <= '0;
            slips_q <= '0;
            skip_q  <= '0;
         end else begin
            unique case (st_q)
               ST_HUNT: if (wvld_i) begin
                  if (word_i == FRAME_WORD) begin
                     if (run_q == MCW'(LOCK_RUN - 1)) st_q <= ST_LOCK;
                     run_q <= run_q + 1'b1;
                  end else begin
                     run_q <= '0;
                     if (slips_q == SCW'(SLIP_LIMIT)) begin
                        st_q <= ST_FAIL;
                     end else begin
                        slip_o  <= 1'b1;
                        slips_q <= slips_q + 1'b1;
                        skip_q  <= WCW'(SKIP_WORDS);
                        st_q    <= ST_SKIP;
                     end
                  end
               end
               ST_SKIP: if (wvld_i) begin
                  skip_q <= skip_q - 1'b1;
                  if (skip_q == WCW'(1)) st_q <= ST_HUNT;
               end
               default: ;
            endcase
         end
      end
   end

   assign locked_o = (st_q == ST_LOCK);
   assign err_o    = (st_q == ST_FAIL);

   p_lock_from_frame_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(locked_o) |-> $past(wvld_i && (word_i == FRAME_WORD)));
   p_slip_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
      slip_o |=> !slip_o);
   p_lock_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (locked_o && !restart_i) |=> locked_o);
   p_err_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (err_o && !restart_i) |=> err_o);
   p_restart_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      restart_i |=> (!locked_o && !err_o));
endmodule

// File: rtl/lane_pair_merge.sv
module lane_pair_merge #(
   parameter int WORD_W = 7,
   parameter int FIFO_D = 4
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [1:0][WORD_W-1:0] word_i,
   input  logic [1:0]             wvld_i,
   input  logic [1:0]             locked_i,
   input  logic [1:0]             delay_i,
   output logic [2*WORD_W-1:0]    sample_o,
   output logic                   valid_o
);
   localparam int IW = $clog2(FIFO_D);
   localparam int FW = $clog2(FIFO_D + 1);

   logic [WORD_W-1:0] fq_q  [2][FIFO_D];
   logic [FW-1:0]     fcnt_q[2];
   logic [WORD_W-1:0] dly_q [2];
   logic [WORD_W-1:0] eff   [2];
   logic [1:0]        delay_q;
   logic              primed_q, both, fire, chg;

   always_comb begin
      both = &locked_i;
      fire = both && (fcnt_q[0] != '0) && (fcnt_q[1] != '0);
      chg  = (delay_i != delay_q);
      for (int l = 0; l < 2; l++) eff[l] = delay_i[l] ? dly_q[l] : fq_q[l][0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int l = 0; l < 2; l++) fcnt_q[l] <= '0;
         delay_q  <= '0;
         primed_q <= 1'b0;
         valid_o  <= 1'b0;
         sample_o <= '0;
      end else begin
         delay_q <= delay_i;
         if (!both) begin
            for (int l = 0; l < 2; l++) fcnt_q[l] <= '0;
            primed_q <= 1'b0;
            valid_o  <= 1'b0;
         end else begin
            for (int l = 0; l < 2; l++) begin
               if (fire) begin
                  for (int e = 0; e < FIFO_D - 1; e++) fq_q[l][e] <= fq_q[l][e+1];
                  dly_q[l] <= fq_q[l][0];
               end
               if (wvld_i[l])
                  fq_q[l][IW'(fcnt_q[l] - FW'(fire))] <= word_i[l];
               fcnt_q[l] <= fcnt_q[l] + FW'(wvld_i[l]) - FW'(fire);
            end
            if (fire) sample_o <= {eff[0], eff[1]};
            valid_o  <= fire && primed_q && !chg;
            primed_q <= chg ? 1'b0 : (primed_q || fire);
         end
      end
   end

   p_valid_needs_lock_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !both |=> !valid_o);
   p_delay_change_r10: assert property (@(posedge clk) disable iff (!rst_n)
      chg |=> !valid_o);

   for (genvar g = 0; g < 2; g++) begin : g_room
      p_queue_room_r8: assert property (@(posedge clk) disable iff (!rst_n)
         (both && wvld_i[g] && !fire) |-> (fcnt_q[g] < FW'(FIFO_D)));
   end
endmodule

// File: rtl/dual_lane_word_aligner.sv
module dual_lane_word_aligner #(
   parameter int           WORD_W       = 7,
   parameter int           BITS_PC      = 2,
   parameter logic [13:0]  FRAME_SAMPLE = 14'h3C78,
   parameter int           LOCK_RUN     = 8,
   parameter int           SKIP_WORDS   = 4,
   parameter int           SLIP_LIMIT   = 7,
   parameter int           FIFO_D       = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [BITS_PC-1:0]  lane0_bits,
   input  logic [BITS_PC-1:0]  lane1_bits,
   input  logic                restart,
   input  logic [1:0]          lane_delay,
   output logic [2*WORD_W-1:0] sample,
   output logic                sample_valid,
   output logic [1:0]          lane_locked,
   output logic [1:0]          lane_error
);
   localparam int NL = 2;

   if (BITS_PC < 1 || BITS_PC >= WORD_W) begin : g_bad_pc
      $error("BITS_PC must lie in 1..WORD_W-1");
   end
   if (2 * WORD_W != 14) begin : g_bad_w
      $error("frame sample width must equal two lane words");
   end
   if (FIFO_D < 2 || (FIFO_D & (FIFO_D - 1)) != 0) begin : g_bad_fd
      $error("FIFO_D must be a power of two of at least 2");
   end
   if (LOCK_RUN < 1 || SKIP_WORDS < 1 || SLIP_LIMIT < 1) begin : g_bad_cnt
      $error("search counts must be positive");
   end

   logic [NL-1:0][BITS_PC-1:0] din;
   logic [NL-1:0][WORD_W-1:0]  word;
   logic [NL-1:0]              wvld, slip;

   assign din[0] = lane0_bits;
   assign din[1] = lane1_bits;

   for (genvar g = 0; g < NL; g++) begin : g_lane
      localparam logic [WORD_W-1:0] LANE_FRAME = FRAME_SAMPLE[(NL-1-g)*WORD_W +: WORD_W];

      lane_gearbox #(.WORD_W(WORD_W), .BITS_PC(BITS_PC)) gbx_i (
         .clk    (clk),
         .rst_n  (rst_n),
         .din_i  (din[g]),
         .slip_i (slip[g]),
         .word_o (word[g]),
         .wvld_o (wvld[g])
      );

      lane_hunter #(
         .WORD_W     (WORD_W),
         .FRAME_WORD (LANE_FRAME),
         .LOCK_RUN   (LOCK_RUN),
         .SKIP_WORDS (SKIP_WORDS),
         .SLIP_LIMIT (SLIP_LIMIT)
      ) hnt_i (
         .clk       (clk),
         .rst_n     (rst_n),
         .restart_i (restart),
         .word_i    (word[g]),
         .wvld_i    (wvld[g]),
         .slip_o    (slip[g]),
         .locked_o  (lane_locked[g]),
         .err_o     (lane_error[g])
      );
   end

   lane_pair_merge #(.WORD_W(WORD_W), .FIFO_D(FIFO_D)) mrg_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .word_i   (word),
      .wvld_i   (wvld),
      .locked_i (lane_locked),
      .delay_i  (lane_delay),
      .sample_o (sample),
      .valid_o  (sample_valid)
   );

   p_valid_locked_r9: assert property (@(posedge clk) disable iff (!rst_n)
      sample_valid |-> $past(lane_locked == 2'b11));
endmodule

// File: tb/dual_lane_word_aligner_tb_top.sv
module dual_lane_word_aligner_tb_top;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  lane0_bits = '0, lane1_bits = '0;
   logic        restart = 1'b0;
   logic [1:0]  lane_delay = '0;
   logic [13:0] sample;
   logic        sample_valid;
   logic [1:0]  lane_locked, lane_error;

   int checks = 0, failures = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dual_lane_word_aligner dut_i (
      .clk(clk), .rst_n(rst_n), .lane0_bits(lane0_bits), .lane1_bits(lane1_bits),
      .restart(restart), .lane_delay(lane_delay), .sample(sample),
      .sample_valid(sample_valid), .lane_locked(lane_locked), .lane_error(lane_error));

   task automatic chk(bit ok, string req, string what, int act, int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%0h expected=%0h t=%0t", req, what, act, exp, $time);
      end
   endtask

   // ---------------- stimulus source ----------------
   bit src [2][$];
   int mode = 0;          // 0 framing, 1 ramp, 2 training toggle
   int rk = 0;
   bit tog = 0;

   function automatic logic [13:0] next_sample();
      logic [13:0] s;
      if (mode == 1) begin
         s = {rk[6:0], rk[6:0]};
         rk++;
      end else if (mode == 2) begin
         s = tog ? 14'h1555 : 14'h2AAA;
         tog = ~tog;
      end else s = 14'h3C78;
      return s;
   endfunction

   always @(negedge clk) begin
      logic [13:0] s;
      bit a, b;
      while (src[0].size() < 2 || src[1].size() < 2) begin
         s = next_sample();
         for (int i = 13; i >= 7; i--) src[0].push_back(s[i]);
         for (int i = 6; i >= 0; i--) src[1].push_back(s[i]);
      end
      a = src[0].pop_front(); b = src[0].pop_front(); lane0_bits = {a, b};
      a = src[1].pop_front(); b = src[1].pop_front(); lane1_bits = {a, b};
   end

   // ---------------- behavioural reference ----------------
   bit          mq [2][$];
   int          m_st[2], m_run[2], m_slips[2], m_skip[2];
   bit          m_slip[2], m_wv[2];
   logic [6:0]  m_w[2];
   logic [6:0]  m_fq [2][$];
   logic [6:0]  m_dly[2];
   bit          m_primed, m_ov;
   logic [1:0]  m_selq;
   logic [13:0] m_out;

   always @(posedge clk) begin
      bit old_slip[2];
      logic [1:0] inb[2];
      inb[0] = lane0_bits; inb[1] = lane1_bits;
      if (!rst_n) begin
         for (int l = 0; l < 2; l++) begin
            mq[l].delete(); m_fq[l].delete();
            m_st[l] = 0; m_run[l] = 0; m_slips[l] = 0; m_skip[l] = 0;
            m_slip[l] = 0; m_wv[l] = 0; m_w[l] = '0;
         end
         m_primed = 0; m_ov = 0; m_selq = '0; m_out = '0;
      end else begin
         // pairing stage uses last cycle's words and lock states
         begin
            bit both, fire, chg;
            logic [6:0] h[2], e[2];
            both = (m_st[0] == 2) && (m_st[1] == 2);
            chg  = (lane_delay != m_selq);
            if (!both) begin
               m_fq[0].delete(); m_fq[1].delete();
               m_primed = 0; m_ov = 0;
            end else begin
               fire = (m_fq[0].size() > 0) && (m_fq[1].size() > 0);
               if (fire) begin
                  for (int l = 0; l < 2; l++) begin
                     h[l] = m_fq[l].pop_front();
                     e[l] = lane_delay[l] ? m_dly[l] : h[l];
                     m_dly[l] = h[l];
                  end
                  m_out = {e[0], e[1]};
               end
               for (int l = 0; l < 2; l++) if (m_wv[l]) m_fq[l].push_back(m_w[l]);
               m_ov = fire && m_primed && !chg;
               m_primed = chg ? 0 : (m_primed || fire);
            end
            m_selq = lane_delay;
         end
         for (int l = 0; l < 2; l++) old_slip[l] = m_slip[l];
         // search stage
         for (int l = 0; l < 2; l++) begin
            m_slip[l] = 0;
            if (restart) begin
               m_st[l] = 0; m_run[l] = 0; m_slips[l] = 0; m_skip[l] = 0;
            end else if (m_st[l] == 0 && m_wv[l]) begin
               if (m_w[l] == 7'b1111000) begin
                  m_run[l]++;
                  if (m_run[l] == 8) m_st[l] = 2;
               end else begin
                  m_run[l] = 0;
                  if (m_slips[l] == 7) m_st[l] = 3;
                  else begin
                     m_slip[l] = 1; m_slips[l]++; m_skip[l] = 4; m_st[l] = 1;
                  end
               end
            end else if (m_st[l] == 1 && m_wv[l]) begin
               m_skip[l]--;
               if (m_skip[l] == 0) m_st[l] = 0;
            end
         end
         // word packing stage
         for (int l = 0; l < 2; l++) begin
            mq[l].push_back(inb[l][1]);
            mq[l].push_back(inb[l][0]);
            if (old_slip[l]) void'(mq[l].pop_front());
            m_wv[l] = 0;
            if (mq[l].size() >= 7) begin
               logic [6:0] wt;
               wt = '0;
               for (int j = 0; j < 7; j++) wt = {wt[5:0], mq[l].pop_front()};
               m_w[l] = wt; m_wv[l] = 1;
            end
         end
      end
   end

   // per-clock comparison, away from the active edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         logic [1:0] el, ee;
         el = {m_st[1] == 2, m_st[0] == 2};
         ee = {m_st[1] == 3, m_st[0] == 3};
         chk(sample_valid == m_ov, "R9,R10", "sample_valid", sample_valid, m_ov);
         if (m_ov) chk(sample == m_out, "R8", "sample", sample, m_out);
         chk(lane_locked == el, "R4,R5", "lane_locked", lane_locked, el);
         chk(lane_error == ee, "R6", "lane_error", lane_error, ee);
      end
   end

   // ---------------- directed flow ----------------
   initial begin
      logic [6:0] hi, lo, prev;
      bit seen, have_prev;
      repeat (3) src[0].push_back(1'b0);
      repeat (8) src[1].push_back(1'b0);
      repeat (4) @(negedge clk);
      // R1 reset state
      chk(sample_valid == 1'b0, "R1", "valid in reset", sample_valid, 0);
      chk(lane_locked == 2'b00, "R1", "locked in reset", lane_locked, 0);
      chk(lane_error == 2'b00, "R1", "error in reset", lane_error, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(sample_valid == 1'b0, "R1", "valid after reset", sample_valid, 0);

      // R3 R5: framing sample drives both lanes to lock
      for (int i = 0; i < 600 && lane_locked != 2'b11; i++) @(negedge clk);
      chk(lane_locked == 2'b11, "R5", "both lanes locked on framing word", lane_locked, 3);
      chk(lane_error == 2'b00, "R3", "no error on framing word", lane_error, 0);

      // R8 R10: ramp data, choose lane delay from lane agreement
      mode = 1;
      repeat (40) @(negedge clk);
      seen = 0;
      for (int i = 0; i < 40 && !seen; i++) begin
         @(negedge clk);
         if (sample_valid) seen = 1;
      end
      chk(seen, "R9", "valid appears with both lanes locked", seen, 1);
      hi = sample[13:7]; lo = sample[6:0];
      if (hi == lo) lane_delay = 2'b00;
      else if (hi == lo + 7'd1) lane_delay = 2'b01;
      else lane_delay = 2'b10;
      chk((hi == lo) || (hi == lo + 7'd1) || (lo == hi + 7'd1), "R8",
          "lane skew within one sample", hi, lo);
      have_prev = 0;
      for (int i = 0; i < 60; i++) begin
         @(negedge clk);
         if (sample_valid) begin
            chk(sample[13:7] == sample[6:0], "R8", "lane halves agree",
                sample[13:7], sample[6:0]);
            if (have_prev)
               chk(sample[13:7] == prev + 7'd1, "R2", "ramp step", sample[13:7], prev + 7'd1);
            prev = sample[13:7]; have_prev = 1;
         end
      end
      chk(have_prev, "R10", "output resumes after delay change", have_prev, 1);

      // R6: training toggle can never match, search must fail
      mode = 2;
      restart = 1'b1;
      @(negedge clk);
      restart = 1'b0;
      chk(lane_locked == 2'b00, "R7", "restart drops lock", lane_locked, 0);
      for (int i = 0; i < 800 && lane_error != 2'b11; i++) @(negedge clk);
      chk(lane_error == 2'b11, "R6", "error after slips exhausted", lane_error, 3);
      repeat (30) @(negedge clk);
      chk(lane_error == 2'b11, "R6", "error stays set", lane_error, 3);
      chk(sample_valid == 1'b0, "R9", "no output while failed", sample_valid, 0);

      // R7: restart re-arms and the framing word locks again
      mode = 0;
      restart = 1'b1;
      @(negedge clk);
      restart = 1'b0;
      chk(lane_error == 2'b00, "R7", "restart clears error", lane_error, 0);
      for (int i = 0; i < 600 && lane_locked != 2'b11; i++) @(negedge clk);
      chk(lane_locked == 2'b11, "R7", "relock after restart", lane_locked, 3);
      repeat (10) @(negedge clk);

      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1;
         checks++;
         failures++;
         $display("FAIL watchdog run did not complete actual=0 expected=1");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule